// File: doc/BRIEF.md
# I2C Buffer-Status DMA Request Logic

This block holds the two buffer-status flags of an I2C peripheral: receive buffer full and transmit buffer empty. The protocol engine sends single-cycle event strobes. The block turns those strobes into flag updates. The flags then drive one DMA request line per channel and a single level-sensitive interrupt line.

The events that set the transmit-buffer-empty flag depend on the operating mode. In master mode, a START or a slave ACK sets it. In slave mode, a shift-register load sets it, and so does an address match with the read/write bit at 1. The flags are cleared by accesses to the data buffers, not by writing 1 to clear. The receive flag is also cleared by a software reset.

Each flag has a DMA enable vector with one bit per channel and an interrupt enable bit. Enabling both DMA and the interrupt for the same flag is a configuration error. In that case DMA takes precedence and the flag's interrupt contribution is masked. The enables are loaded together through a configuration write strobe.

Top module: `i2c_bufdma`

## Requirements
- R1: A `rx_load_i` pulse sets `rx_full_o`, which reads 1 from the clock edge on which the pulse is sampled.
- R2: `rx_read_i` or `soft_rst_i` clears `rx_full_o` at the next edge. The software reset leaves every stored enable bit unchanged.
- R3: While `master_i`=1, `start_issued_i` or `ack_rcvd_i` sets `tx_empty_o`. In this mode `tx_shift_load_i` and `addr_match_i` have no effect on the flag.
- R4: While `master_i`=0, two events set `tx_empty_o`: `tx_shift_load_i`, or `addr_match_i` with `addr_rw_i`=1. An address match with `addr_rw_i`=0 has no effect, and neither do `start_issued_i` and `ack_rcvd_i`.
- R5: `tx_write_i` clears `tx_empty_o` at the next edge.
- R6: When a flag's set event and clear access arrive in the same cycle, the flag ends up set.
- R7: Bit c of `dma_req_o` is 1 exactly while (`rx_full_o` AND stored rx DMA enable bit c) OR (`tx_empty_o` AND stored tx DMA enable bit c).
- R8: `irq_o` is a level. It is the OR, taken over both flags, of the flag ANDed with its interrupt enable. A flag's term is forced to 0 while any of that flag's DMA enable bits is set.
- R9: After `rst_ni` is asserted, both flags, all enables, `dma_req_o` and `irq_o` are 0.
- R10: All enable inputs are stored on a clock edge where `cfg_we_i`=1 and take effect from that edge. When `cfg_we_i`=0 they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| rx_load_i | input | 1 | Received byte loaded into receive buffer |
| rx_read_i | input | 1 | Receive data register read |
| tx_write_i | input | 1 | Transmit data register written |
| start_issued_i | input | 1 | START condition issued (master) |
| ack_rcvd_i | input | 1 | ACK received from slave (master) |
| tx_shift_load_i | input | 1 | Transmit buffer moved to shift register (slave) |
| addr_match_i | input | 1 | Own address matched (slave) |
| addr_rw_i | input | 1 | Read/write bit of the matched address |
| soft_rst_i | input | 1 | Software reset of the peripheral |
| cfg_we_i | input | 1 | Load all enable inputs |
| rx_dma_en_i | input | NCH | Per-channel DMA enable, receive flag |
| tx_dma_en_i | input | NCH | Per-channel DMA enable, transmit flag |
| rx_irq_en_i | input | 1 | Interrupt enable, receive flag |
| tx_irq_en_i | input | 1 | Interrupt enable, transmit flag |
| rx_full_o | output | 1 | Receive buffer full flag |
| tx_empty_o | output | 1 | Transmit buffer empty flag |
| dma_req_o | output | NCH | DMA request per channel |
| irq_o | output | 1 | Combined interrupt, level |

## Verification
Each set strobe is applied in its own mode and in the opposite mode. This separates correct mode steering from an OR of all events. Address matches are applied with both read/write values, which exposes a decoder that ignores the direction bit. Set and clear accesses are applied in the same cycle, which shows whether set takes precedence.

Channel enable patterns that differ between the two flags show whether the per-channel OR uses the right vector. Interrupt enables are applied with and without DMA enabled for the same flag, which tests the masking. A software reset followed by a new receive event, with no fresh configuration write, shows that the stored enables survive.

// File: rtl/i2c_bufdma_pkg.sv
package i2c_bufdma_pkg;
  localparam int NUM_FLAGS = 2;

  typedef enum int {
    FLAG_RX = 0,
    FLAG_TX = 1
  } flag_e;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_ev_t;
endpackage

// File: rtl/i2c_bufdma_evt.sv
module i2c_bufdma_evt
  import i2c_bufdma_pkg::*;
(
  input  logic                      master_i,
  input  logic                      rx_load_i,
  input  logic                      rx_read_i,
  input  logic                      tx_write_i,
  input  logic                      start_issued_i,
  input  logic                      ack_rcvd_i,
  input  logic                      tx_shift_load_i,
  input  logic                      addr_match_i,
  input  logic                      addr_rw_i,
  input  logic                      soft_rst_i,
  output flag_ev_t [NUM_FLAGS-1:0]  ev_o
);
  logic tx_set_mst, tx_set_slv;

  assign tx_set_mst = start_issued_i | ack_rcvd_i;
  assign tx_set_slv = tx_shift_load_i | (addr_match_i & addr_rw_i);

  always_comb begin
    ev_o[FLAG_RX].set = rx_load_i;
    ev_o[FLAG_RX].clr = rx_read_i | soft_rst_i;
    ev_o[FLAG_TX].set = master_i ? tx_set_mst : tx_set_slv;
    ev_o[FLAG_TX].clr = tx_write_i;
  end
endmodule

// File: rtl/i2c_bufdma_flag.sv
module i2c_bufdma_flag
  import i2c_bufdma_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  flag_ev_t ev_i,
  output logic     flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (ev_i.set)   flag_o <= 1'b1;  // set beats clear
    else if (ev_i.clr)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_bufdma_cfg.sv
module i2c_bufdma_cfg
  import i2c_bufdma_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [NUM_FLAGS-1:0][NCH-1:0]  dma_en_i,
  input  logic [NUM_FLAGS-1:0]           irq_en_i,
  output logic [NUM_FLAGS-1:0][NCH-1:0]  dma_en_o,
  output logic [NUM_FLAGS-1:0]           irq_en_o
);
  // soft reset deliberately not routed here: enables survive it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_o <= '0;
      irq_en_o <= '0;
    end else if (we_i) begin
      dma_en_o <= dma_en_i;
      irq_en_o <= irq_en_i;
    end
  end
endmodule

// File: rtl/i2c_bufdma_req.sv
module i2c_bufdma_req
  import i2c_bufdma_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NUM_FLAGS-1:0]           flag_i,
  input  logic [NUM_FLAGS-1:0][NCH-1:0]  dma_en_i,
  input  logic [NUM_FLAGS-1:0]           irq_en_i,
  output logic [NCH-1:0]                 dma_req_o,
  output logic                           irq_o
);
  logic [NUM_FLAGS-1:0] dma_owned;
  logic [NUM_FLAGS-1:0] irq_term;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NUM_FLAGS-1:0] hit;
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_fl
      assign hit[f] = flag_i[f] & dma_en_i[f][c];
    end
    assign dma_req_o[c] = |hit;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_irq
    assign dma_owned[f] = |dma_en_i[f];
    // DMA claims the flag: interrupt path masked
    assign irq_term[f]  = flag_i[f] & irq_en_i[f] & ~dma_owned[f];
  end

  assign irq_o = |irq_term;
endmodule

// File: rtl/i2c_bufdma.sv
module i2c_bufdma
  import i2c_bufdma_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           master_i,
  input  logic           rx_load_i,
  input  logic           rx_read_i,
  input  logic           tx_write_i,
  input  logic           start_issued_i,
  input  logic           ack_rcvd_i,
  input  logic           tx_shift_load_i,
  input  logic           addr_match_i,
  input  logic           addr_rw_i,
  input  logic           soft_rst_i,
  input  logic           cfg_we_i,
  input  logic [NCH-1:0] rx_dma_en_i,
  input  logic [NCH-1:0] tx_dma_en_i,
  input  logic           rx_irq_en_i,
  input  logic           tx_irq_en_i,
  output logic           rx_full_o,
  output logic           tx_empty_o,
  output logic [NCH-1:0] dma_req_o,
  output logic           irq_o
);
  flag_ev_t [NUM_FLAGS-1:0]          ev;
  logic     [NUM_FLAGS-1:0]          flag_q;
  logic     [NUM_FLAGS-1:0][NCH-1:0] dma_en_d, dma_en_q;
  logic     [NUM_FLAGS-1:0]          irq_en_d, irq_en_q;

  assign dma_en_d[FLAG_RX] = rx_dma_en_i;
  assign dma_en_d[FLAG_TX] = tx_dma_en_i;
  assign irq_en_d[FLAG_RX] = rx_irq_en_i;
  assign irq_en_d[FLAG_TX] = tx_irq_en_i;

  i2c_bufdma_evt u_evt (
    .master_i        (master_i),
    .rx_load_i       (rx_load_i),
    .rx_read_i       (rx_read_i),
    .tx_write_i      (tx_write_i),
    .start_issued_i  (start_issued_i),
    .ack_rcvd_i      (ack_rcvd_i),
    .tx_shift_load_i (tx_shift_load_i),
    .addr_match_i    (addr_match_i),
    .addr_rw_i       (addr_rw_i),
    .soft_rst_i      (soft_rst_i),
    .ev_o            (ev)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    i2c_bufdma_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev[f]),
      .flag_o (flag_q[f])
    );
  end

  i2c_bufdma_cfg #(.NCH(NCH)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .dma_en_i (dma_en_d),
    .irq_en_i (irq_en_d),
    .dma_en_o (dma_en_q),
    .irq_en_o (irq_en_q)
  );

  i2c_bufdma_req #(.NCH(NCH)) u_req (
    .flag_i    (flag_q),
    .dma_en_i  (dma_en_q),
    .irq_en_i  (irq_en_q),
    .dma_req_o (dma_req_o),
    .irq_o     (irq_o)
  );

  assign rx_full_o  = flag_q[FLAG_RX];
  assign tx_empty_o = flag_q[FLAG_TX];
endmodule

// File: rtl/i2c_bufdma_chk.sv
module i2c_bufdma_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           master_i,
  input logic           rx_load_i,
  input logic           rx_read_i,
  input logic           tx_write_i,
  input logic           start_issued_i,
  input logic           ack_rcvd_i,
  input logic           tx_shift_load_i,
  input logic           addr_match_i,
  input logic           addr_rw_i,
  input logic           soft_rst_i,
  input logic           rx_full_o,
  input logic           tx_empty_o,
  input logic [NCH-1:0] dma_req_o,
  input logic           irq_o
);
  logic mst_evt, slv_evt;
  assign mst_evt = master_i & (start_issued_i | ack_rcvd_i);
  assign slv_evt = ~master_i & (tx_shift_load_i | (addr_match_i & addr_rw_i));

  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_i |=> rx_full_o); // R1
  AST_RX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_read_i || soft_rst_i) && !rx_load_i) |=> !rx_full_o); // R2
  AST_TX_SET_MST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_evt |=> tx_empty_o); // R3
  AST_TX_SET_SLV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_evt |=> tx_empty_o); // R4
  AST_TX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_write_i && !mst_evt && !slv_evt) |=> !tx_empty_o); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_i && rx_read_i) |=> rx_full_o); // R6
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_full_o && !tx_empty_o) |-> (dma_req_o == '0)); // R7
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rx_full_o || tx_empty_o)); // R8
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_write_i && !mst_evt && !slv_evt) |=> $stable(tx_empty_o)); // R4
endmodule

bind i2c_bufdma i2c_bufdma_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/i2c_bufdma_tb_top.sv
`timescale 1ns/1ps
module i2c_bufdma_tb_top;
  localparam int NCH = 4;

  typedef struct packed {
    logic           master, rx_load, rx_read, tx_write, start, ack;
    logic           shift, match, rw, srst, we;
    logic [NCH-1:0] rx_dma, tx_dma;
    logic           rx_irq, tx_irq;
  } stim_t;

  typedef struct packed {
    logic           rx, tx;
    logic [NCH-1:0] dma;
    logic           irq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  stim_t s;
  logic           rx_full, tx_empty, irq;
  logic [NCH-1:0] dma_req;

  i2c_bufdma #(.NCH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(s.master),
    .rx_load_i(s.rx_load), .rx_read_i(s.rx_read), .tx_write_i(s.tx_write),
    .start_issued_i(s.start), .ack_rcvd_i(s.ack), .tx_shift_load_i(s.shift),
    .addr_match_i(s.match), .addr_rw_i(s.rw), .soft_rst_i(s.srst),
    .cfg_we_i(s.we), .rx_dma_en_i(s.rx_dma), .tx_dma_en_i(s.tx_dma),
    .rx_irq_en_i(s.rx_irq), .tx_irq_en_i(s.tx_irq),
    .rx_full_o(rx_full), .tx_empty_o(tx_empty), .dma_req_o(dma_req), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  // reference state
  logic           m_rx, m_tx, m_rxi, m_txi;
  logic [NCH-1:0] m_rxd, m_txd;

  function automatic exp_t model_out();
    exp_t e;
    e.rx  = m_rx;
    e.tx  = m_tx;
    e.dma = ({NCH{m_rx}} & m_rxd) | ({NCH{m_tx}} & m_txd);
    e.irq = (m_rx & m_rxi & ~(|m_rxd)) | (m_tx & m_txi & ~(|m_txd));
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t a;
    a = '{rx: rx_full, tx: tx_empty, dma: dma_req, irq: irq};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual rx=%b tx=%b dma=%b irq=%b expected rx=%b tx=%b dma=%b irq=%b",
               tag, a.rx, a.tx, a.dma, a.irq, e.rx, e.tx, e.dma, e.irq);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed for after the edge
  task automatic step(input stim_t st, input string tag);
    logic tx_set;
    @(negedge clk);
    s = st;
    if (st.rx_load)                 m_rx = 1'b1;
    else if (st.rx_read || st.srst) m_rx = 1'b0;
    tx_set = st.master ? (st.start | st.ack) : (st.shift | (st.match & st.rw));
    if (tx_set)           m_tx = 1'b1;
    else if (st.tx_write) m_tx = 1'b0;
    if (st.we) begin
      m_rxd = st.rx_dma; m_txd = st.tx_dma;
      m_rxi = st.rx_irq; m_txi = st.tx_irq;
    end
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  function automatic stim_t idle(input logic mst);
    stim_t t = '0;
    t.master = mst;
    return t;
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    stim_t t;
    s = '0;
    m_rx = 0; m_tx = 0; m_rxi = 0; m_txi = 0; m_rxd = '0; m_txd = '0;
    repeat (3) @(posedge clk);
    #1;
    compare(model_out(), "R9 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R10: load enables
    t = idle(1); t.we = 1; t.rx_dma = 4'b0001; t.tx_dma = 4'b0100;
    step(t, "R10 cfg load");
    // R1 / R7
    t = idle(1); t.rx_load = 1;            step(t, "R1 rx set, R7 req");
    t = idle(1); t.rx_read = 1;            step(t, "R2 rx read clear");
    // master mode
    t = idle(1); t.start = 1;              step(t, "R3 start sets tx");
    t = idle(1); t.tx_write = 1;           step(t, "R5 tx write clears");
    t = idle(1); t.ack = 1;                step(t, "R3 ack sets tx");
    t = idle(1); t.tx_write = 1;           step(t, "R5 tx write clears");
    t = idle(1); t.shift = 1;              step(t, "R3 shift ignored in master");
    t = idle(1); t.match = 1; t.rw = 1;    step(t, "R3 match ignored in master");
    // slave mode
    t = idle(0); t.shift = 1;              step(t, "R4 shift sets tx");
    t = idle(0); t.tx_write = 1;           step(t, "R5 tx write clears");
    t = idle(0); t.match = 1; t.rw = 0;    step(t, "R4 match rw0 ignored");
    t = idle(0); t.start = 1; t.ack = 1;   step(t, "R4 master events ignored");
    t = idle(0); t.match = 1; t.rw = 1;    step(t, "R4 match rw1 sets tx");
    t = idle(0);                           step(t, "R4 tx holds");
    // R6 set wins
    t = idle(0); t.tx_write = 1; t.shift = 1; step(t, "R6 tx set beats write");
    t = idle(0); t.rx_load = 1; t.rx_read = 1; step(t, "R6 rx set beats read");
    t = idle(0); t.rx_load = 1; t.srst = 1;   step(t, "R6 rx set beats soft reset");
    // R7 both flags, other channel pattern
    t = idle(0); t.we = 1; t.rx_dma = 4'b1010; t.tx_dma = 4'b0011;
    step(t, "R7 mixed channels");
    // R10 ignored write
    t = idle(0); t.we = 0; t.rx_dma = 4'b1111; t.tx_dma = 4'b1111; t.rx_irq = 1; t.tx_irq = 1;
    step(t, "R10 no write ignored");
    // R8 irq without dma
    t = idle(0); t.we = 1; t.rx_irq = 1; t.tx_irq = 1; step(t, "R8 irq both flags");
    t = idle(0); t.tx_write = 1;           step(t, "R8 irq from rx only");
    t = idle(0); t.we = 1; t.rx_irq = 1; t.rx_dma = 4'b0100;
    step(t, "R8 irq masked by rx dma");
    t = idle(0); t.start = 1; t.shift = 1; step(t, "R8 tx irq disabled");
    // R2 soft reset keeps enables
    t = idle(0); t.srst = 1;               step(t, "R2 soft reset clears rx");
    t = idle(0); t.tx_write = 1;           step(t, "R5 tx clear");
    t = idle(0); t.rx_load = 1;            step(t, "R2 enables kept after soft reset");
    t = idle(0); t.srst = 1; t.tx_write = 1; step(t, "R2 soft reset tx untouched");
    t = idle(0);                           step(t, "R9 idle");

    repeat (3) @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule